// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight level-sensitive interrupt requests and drives a single interrupt line to a processor. Each cycle it samples the request inputs into a request register. Requests blocked by the mask register are dropped. Among the rest, it picks the one with the best priority. It raises the interrupt line only if that request outranks every level currently held in the in-service register. As a result, lower levels wait while a handler runs, and higher levels can nest above it.

The processor answers the interrupt line with a one-cycle acknowledge pulse. On that pulse the winning level moves into service and its 3-bit index appears on the vector output. When the handler finishes, the processor writes an end-of-interrupt command. The same write port loads the mask and issues priority commands.

Priority is fixed by default, with level 0 highest and level 7 lowest. A command can name any level as the lowest, which rotates the whole order so that the next level up becomes the highest. In the automatic mode, each end-of-interrupt that clears a level also moves that level to the bottom of the order.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask, request and in-service registers are all zero, automatic rotation is off, level 7 is the lowest priority, `irq_o` is 0 and `vec_o` is 0.
- R2: With the default order, when several unmasked requests are pending and nothing is in service, an acknowledge returns the smallest pending index.
- R3: A write with `wr_sel_i`=0 loads `wr_data_i[7:0]` into the mask. A mask bit of 1 blocks that level. The new mask governs `irq_o` from the cycle after the write.
- R4: `irq_o` is 1 exactly when some unmasked sampled request has a better priority than every in-service level. With nothing in service, any unmasked request qualifies.
- R5: An acknowledge while `irq_o` is 1 sets the in-service bit of the winning level, clears its request bit for one cycle, and shows the level on `vec_o` from the next cycle. An acknowledge while `irq_o` is 0 changes no in-service bit and sets `vec_o` to 7.
- R6: A command write (`wr_sel_i`=1) with `wr_data_i[7:6]`=00 clears the in-service bit that has the best priority in the current order.
- R7: A command with `wr_data_i[7:6]`=01 clears the in-service bit of the level in `wr_data_i[2:0]`.
- R8: A command with `wr_data_i[7:6]`=10 makes the level in `wr_data_i[2:0]` the lowest priority. The next level up, modulo 8, becomes the highest, and priority continues in ascending order from there.
- R9: A command with `wr_data_i[7:6]`=11 sets automatic rotation to `wr_data_i[0]`. While it is on, any end-of-interrupt that clears a set bit makes that level the lowest priority.
- R10: Requests are sampled every cycle. A request shows on `irq_o` one cycle after it is presented, and it disappears one cycle after it is withdrawn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Level interrupt requests, bit n is level n |
| wr_en_i | input | 1 | Write strobe for mask or command |
| wr_sel_i | input | 1 | 0 selects mask, 1 selects command |
| wr_data_i | input | 8 | Mask value or command word |
| ack_i | input | 1 | One-cycle interrupt acknowledge |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 3 | Index of the last acknowledged level (7 if spurious) |

## Verification
The bench targets nesting. It checks that a lower request stays silent while a higher level is in service, and that a better one breaks through. A design that compared against the mask alone would interrupt a running handler with lower-priority work. An acknowledge with no qualifying request must return vector 7 and leave the in-service register untouched; a faulty design would put a phantom level into service. Rotation cases confirm that the winner follows the chosen lowest level, and that in automatic mode a cleared level sinks to the bottom. A design that rotated around the wrong index would return the wrong vector when two requests straddle the rotation point.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int unsigned NUM_IRQ = 8;
    localparam int unsigned CMD_W   = 8;

    typedef enum logic [1:0] {
        OP_EOI    = 2'b00,
        OP_SEOI   = 2'b01,
        OP_LOWEST = 2'b10,
        OP_MODE   = 2'b11
    } cmd_op_e;
endpackage

// File: rtl/prio_irq_resolve.sv
module prio_irq_resolve #(
    parameter int unsigned N = 8,
    parameter int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    input  logic [W-1:0] base_i,
    output logic         found_o,
    output logic [W-1:0] idx_o,
    output logic [W:0]   rank_o
);
    localparam int unsigned RW = W + 1;

    // Scan from worst rank to best so the best-ranked hit is written last.
    always_comb begin
        logic [RW-1:0] pos;
        found_o = 1'b0;
        idx_o   = '0;
        rank_o  = RW'(N);
        for (int r = N - 1; r >= 0; r--) begin
            pos = {1'b0, base_i} + RW'(r);
            if (pos >= RW'(N)) pos = pos - RW'(N);
            if (vec_i[pos[W-1:0]]) begin
                found_o = 1'b1;
                idx_o   = pos[W-1:0];
                rank_o  = RW'(r);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int unsigned N  = NUM_IRQ,
    parameter int unsigned DW = CMD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic          wr_en_i,
    input  logic          wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          ack_i,
    output logic          irq_o,
    output logic [$clog2(N)-1:0] vec_o
);
    localparam int unsigned W = $clog2(N);

    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] irr;
        logic [N-1:0] isr;
        logic [W-1:0] lowest;
        logic [W-1:0] vec;
        logic         auto_rot;
    } state_t;

    localparam state_t RST_STATE = '{
        mask: '0, irr: '0, isr: '0,
        lowest: W'(N - 1), vec: '0, auto_rot: 1'b0
    };

    state_t st_q, st_d;

    logic [W-1:0] base;
    logic         pend_found, isr_found;
    logic [W-1:0] pend_idx, isr_idx;
    logic [W:0]   pend_rank, isr_rank;
    logic         irq;
    logic [N-1:0] pend_vec;
    logic [W-1:0] cmd_lvl;
    logic [1:0]   cmd_op;

    assign base     = (st_q.lowest == W'(N - 1)) ? '0 : st_q.lowest + W'(1);
    assign pend_vec = st_q.irr & ~st_q.mask;
    assign cmd_lvl  = wr_data_i[W-1:0];
    assign cmd_op   = wr_data_i[DW-1 -: 2];

    prio_irq_resolve #(.N(N), .W(W)) u_pend (
        .vec_i(pend_vec), .base_i(base),
        .found_o(pend_found), .idx_o(pend_idx), .rank_o(pend_rank)
    );

    prio_irq_resolve #(.N(N), .W(W)) u_isr (
        .vec_i(st_q.isr), .base_i(base),
        .found_o(isr_found), .idx_o(isr_idx), .rank_o(isr_rank)
    );

    // isr_rank equals N when nothing is in service.
    assign irq = pend_found && (pend_rank < isr_rank);

    always_comb begin
        logic [N-1:0] clr_mask;
        logic [N-1:0] set_mask;
        logic         eoi_hit;
        logic [W-1:0] eoi_lvl;
        st_d     = st_q;
        st_d.irr = req_i;
        clr_mask = '0;
        set_mask = '0;
        eoi_hit  = 1'b0;
        eoi_lvl  = '0;
        if (wr_en_i) begin
            if (!wr_sel_i) begin
                st_d.mask = wr_data_i[N-1:0];
            end else begin
                case (cmd_op)
                    OP_EOI: begin
                        if (isr_found) begin
                            clr_mask[isr_idx] = 1'b1;
                            eoi_hit = 1'b1;
                            eoi_lvl = isr_idx;
                        end
                    end
                    OP_SEOI: begin
                        if (st_q.isr[cmd_lvl]) begin
                            clr_mask[cmd_lvl] = 1'b1;
                            eoi_hit = 1'b1;
                            eoi_lvl = cmd_lvl;
                        end
                    end
                    OP_LOWEST: st_d.lowest   = cmd_lvl;
                    default:   st_d.auto_rot = wr_data_i[0];
                endcase
            end
        end
        if (eoi_hit && st_q.auto_rot) st_d.lowest = eoi_lvl;
        if (ack_i) begin
            if (irq) begin
                set_mask[pend_idx] = 1'b1;
                st_d.irr[pend_idx] = 1'b0;
                st_d.vec = pend_idx;
            end else begin
                st_d.vec = W'(N - 1);
            end
        end
        st_d.isr = (st_q.isr & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign irq_o = irq;
    assign vec_o = st_q.vec;

    AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((st_q.irr & ~st_q.mask) != '0)) else $error("irq without unmasked request"); // R4
    AST_WINNER_NOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !st_q.mask[pend_idx]) else $error("masked level won"); // R3
    AST_WINNER_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !st_q.isr[pend_idx]) else $error("winner already in service"); // R4
    AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> st_q.isr[vec_o]) else $error("ack did not set in-service"); // R5
    AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o) |=> (vec_o == W'(N - 1))) else $error("spurious vector wrong"); // R5
    AST_EOI_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i && cmd_op == OP_EOI && !ack_i && isr_found)
        |=> ($countones(st_q.isr) + 1 == $countones($past(st_q.isr)))) else $error("EOI did not clear one bit"); // R6
    AST_LOWEST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i && cmd_op == OP_LOWEST) |=> (st_q.lowest == $past(cmd_lvl))) else $error("lowest not loaded"); // R8
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_i;
    logic       wr_en_i;
    logic       wr_sel_i;
    logic [7:0] wr_data_i;
    logic       ack_i;
    logic       irq_o;
    logic [2:0] vec_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] m_mask, m_irr, m_isr;
    logic [2:0] m_low, m_vec;
    logic       m_auto;

    always #(CLK_P/2) clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .ack_i(ack_i),
        .irq_o(irq_o), .vec_o(vec_o)
    );

    function automatic int rank_of(logic [7:0] v, logic [2:0] low);
        for (int r = 0; r < 8; r++)
            if (v[(int'(low) + 1 + r) % 8]) return r;
        return 8;
    endfunction

    function automatic logic [2:0] lvl_at(int r, logic [2:0] low);
        return 3'((int'(low) + 1 + r) % 8);
    endfunction

    function automatic logic model_irq();
        return rank_of(m_irr & ~m_mask, m_low) < rank_of(m_isr, m_low);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge: drive, advance model and design, check at next negedge.
    task automatic step(logic [7:0] rq, logic we, logic sel, logic [7:0] dat, logic ak, string tag);
        logic [7:0] n_mask, n_irr, n_isr, clr, setb;
        logic [2:0] n_low, n_vec, rl;
        logic       n_auto, rot, irq_now;
        int pr, ir;
        req_i = rq; wr_en_i = we; wr_sel_i = sel; wr_data_i = dat; ack_i = ak;
        pr = rank_of(m_irr & ~m_mask, m_low);
        ir = rank_of(m_isr, m_low);
        irq_now = pr < ir;
        n_mask = m_mask; n_irr = rq; n_low = m_low; n_vec = m_vec; n_auto = m_auto;
        clr = '0; setb = '0; rot = 0; rl = '0;
        if (we) begin
            if (!sel) n_mask = dat;
            else case (dat[7:6])
                2'b00: if (ir < 8) begin rl = lvl_at(ir, m_low); clr[rl] = 1; rot = 1; end
                2'b01: if (m_isr[dat[2:0]]) begin rl = dat[2:0]; clr[rl] = 1; rot = 1; end
                2'b10: n_low = dat[2:0];
                default: n_auto = dat[0];
            endcase
        end
        if (rot && m_auto) n_low = rl;
        if (ak) begin
            if (irq_now) begin
                setb[lvl_at(pr, m_low)] = 1;
                n_irr[lvl_at(pr, m_low)] = 0;
                n_vec = lvl_at(pr, m_low);
            end else n_vec = 3'd7;
        end
        n_isr = (m_isr & ~clr) | setb;
        @(posedge clk);
        m_mask = n_mask; m_irr = n_irr; m_isr = n_isr; m_low = n_low; m_vec = n_vec; m_auto = n_auto;
        @(negedge clk);
        chk({tag, " irq"}, int'(irq_o), int'(model_irq()));
        chk({tag, " vec"}, int'(vec_o), int'(m_vec));
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        rst_n = 0; req_i = 0; wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0; ack_i = 0;
        m_mask = 0; m_irr = 0; m_isr = 0; m_low = 3'd7; m_vec = 0; m_auto = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 vec", int'(vec_o), 0);

        // R10: request visible one cycle later; R2: lowest index wins
        step(8'hA8, 0, 0, 8'h00, 0, "R10");
        chk("R10 raised", int'(irq_o), 1);
        step(8'hA8, 0, 0, 8'h00, 1, "R2");
        chk("R2 vector", int'(vec_o), 3);
        // R4: level 5 blocked under level 3, level 1 nests above
        step(8'h20, 0, 0, 8'h00, 0, "R4");
        chk("R4 blocked", int'(irq_o), 0);
        step(8'h22, 0, 0, 8'h00, 0, "R4");
        chk("R4 nest", int'(irq_o), 1);
        step(8'h22, 0, 0, 8'h00, 1, "R5");
        chk("R5 vector", int'(vec_o), 1);
        // R6: non-specific EOI clears level 1, leaves 3
        step(8'h20, 1, 1, 8'h00, 0, "R6");
        chk("R6 still blocked", int'(irq_o), 0);
        // R7: specific EOI on level 3
        step(8'h20, 1, 1, 8'h43, 0, "R7");
        chk("R7 freed", int'(irq_o), 1);
        // R3: mask takes effect next cycle
        step(8'h20, 1, 0, 8'hFF, 0, "R3");
        chk("R3 masked", int'(irq_o), 0);
        step(8'h20, 1, 0, 8'h00, 0, "R3");
        // R10: withdrawn request vanishes
        step(8'h00, 0, 0, 8'h00, 0, "R10");
        chk("R10 dropped", int'(irq_o), 0);
        // R5: spurious ack
        step(8'h00, 0, 0, 8'h00, 1, "R5");
        chk("R5 spurious", int'(vec_o), 7);
        // R8: level 2 lowest, so 4 beats 0
        step(8'h11, 1, 1, 8'h82, 0, "R8");
        step(8'h11, 0, 0, 8'h00, 1, "R8");
        chk("R8 rotated win", int'(vec_o), 4);
        // R9: auto mode, EOI on 4 makes 4 lowest, so 5 beats 0
        step(8'h00, 1, 1, 8'hC1, 0, "R9");
        step(8'h21, 1, 1, 8'h00, 0, "R9");
        step(8'h21, 0, 0, 8'h00, 1, "R9");
        chk("R9 auto win", int'(vec_o), 5);
        step(8'h00, 1, 1, 8'h00, 0, "R9");
        step(8'h00, 1, 1, 8'hC0, 0, "R9");
        step(8'h00, 1, 1, 8'h87, 0, "R8");

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] rq, dat;
            logic we, sel, ak;
            rq  = 8'($urandom) & 8'($urandom);
            we  = ($urandom % 5) == 0;
            sel = ($urandom % 3) != 0;
            dat = 8'($urandom);
            if (!sel) dat = dat & 8'($urandom) & 8'($urandom);
            ak  = ($urandom % 3) == 0;
            step(rq, we, sel, dat, ak, "R4 R5 R6 R7 R8 R9 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule